// File: doc/BRIEF.md
# I/O Read Data-Bit Masking

This block decides which host data-bus bits are actually driven when the host reads from a card through an I/O window. Two devices sometimes answer at one legacy I/O address. The classic case is the drive status ports at 3F7h and 377h, where one controller supplies the top bit and another supplies the low seven. Each I/O window has a 2-bit mode field. The mode makes the block drive the whole byte, leave the top bit to another device, or drive only the top bit.

An upstream decoder supplies the per-window hit lines and a flag marking a memory-window cycle. Memory reads are never masked. When several I/O windows hit, the lowest-numbered window's mode applies. The per-bit output enables and the returned data are registered, so they change only on a clock edge and cannot glitch within a cycle. Bits that are not driven carry zero on the data output.

Top module: `io_rd_bitmask`

## Requirements
- R1: After reset, `host_oe` and `host_rdata` are all zero.
- R2: When `rd_strobe` is low at a rising edge, `host_oe` is zero after that edge.
- R3: On an I/O read whose selected window mode is 2'b00, all bits of `host_oe` are set after the edge and `host_rdata` equals `card_rdata` sampled at that edge.
- R4: On an I/O read whose selected mode is 2'b01, `host_oe` is 8'h7F, so bit 7 is not driven and bits 6:0 are driven.
- R5: On an I/O read whose selected mode is 2'b10, `host_oe` is 8'h80, so only bit 7 is driven.
- R6: Mode 2'b11 behaves exactly like mode 2'b00.
- R7: When several bits of `io_win_hit` are set, the mode of the lowest-numbered hitting window is used. Window i's mode is `io_win_mode[2i+1:2i]`.
- R8: A read with `mem_cycle` high drives all bits, whatever the hits and the modes are.
- R9: A read with `mem_cycle` low and no window hit drives no bits.
- R10: Outputs reflect the inputs sampled at the previous rising edge, which is a latency of exactly one cycle.
- R11: Every bit of `host_rdata` whose enable bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_strobe | input | 1 | Host read strobe, active high |
| mem_cycle | input | 1 | The current cycle targets a memory window |
| io_win_hit | input | NWIN | Hit lines, one per I/O window |
| io_win_mode | input | 2*NWIN | Mask mode for each window, 2 bits per window |
| card_rdata | input | DW | Data read from the card |
| host_oe | output | DW | Registered per-bit drive enable for the host bus |
| host_rdata | output | DW | Registered data for the host bus, with undriven bits zero |

## Verification
Any wrong internal state shows as a wrong `host_oe` or `host_rdata` one edge after the faulty inputs are sampled. No state persists beyond that one cycle. A priority picker that selects the wrong window shows up only when several windows with different modes hit together, so the stimulus deliberately mixes overlapping hits with different per-window modes. A mode decoder that confuses the encodings shows up as an enable pattern of 7F, 80 or FF in the wrong case. Each read is therefore checked at the following edge against the full enable byte.

// File: rtl/io_rd_bitmask_pkg.sv
package io_rd_bitmask_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_ALL     = 2'b00,
        MODE_LOW     = 2'b01,
        MODE_TOP     = 2'b10,
        MODE_ALL_ALT = 2'b11
    } mask_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] oe;
        logic [DATA_W-1:0] data;
    } drive_t;

endpackage

// File: rtl/io_rd_win_pick.sv
// Lowest-index-wins selection of the window mode among hitting windows.
module io_rd_win_pick #(
    parameter int NWIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWIN-1:0]   hit,
    input  logic [2*NWIN-1:0] modes,
    output logic              any_hit,
    output logic [1:0]        sel_mode
);
    logic [NWIN-1:0] seen;
    logic [NWIN-1:0] grant;

    genvar gi;
    generate
        for (gi = 0; gi < NWIN; gi++) begin : g_chain
            if (gi == 0) begin : g_first
                assign seen[gi]  = hit[gi];
                assign grant[gi] = hit[gi];
            end else begin : g_rest
                assign seen[gi]  = seen[gi-1] | hit[gi];
                assign grant[gi] = hit[gi] & ~seen[gi-1];
            end
        end
    endgenerate

    always_comb begin
        sel_mode = 2'b00;
        for (int i = 0; i < NWIN; i++) begin
            sel_mode |= grant[i] ? modes[2*i +: 2] : 2'b00;
        end
    end

    assign any_hit = seen[NWIN-1];

    // R7: at most one window granted, and only a hitting one
    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~hit) == '0));

endmodule

// File: rtl/io_rd_mode_dec.sv
// Turns a 2-bit mask mode into a per-bit drive mask; the top bit is the split point.
module io_rd_mode_dec #(
    parameter int DW = 8
) (
    input  logic [1:0]    mode,
    output logic [DW-1:0] mask
);
    import io_rd_bitmask_pkg::*;

    logic top_on;
    logic low_on;

    always_comb begin
        unique case (mask_mode_e'(mode))
            MODE_LOW: begin top_on = 1'b0; low_on = 1'b1; end
            MODE_TOP: begin top_on = 1'b1; low_on = 1'b0; end
            default:  begin top_on = 1'b1; low_on = 1'b1; end
        endcase
    end

    genvar bi;
    generate
        for (bi = 0; bi < DW; bi++) begin : g_bit
            if (bi == DW-1) begin : g_top
                assign mask[bi] = top_on;
            end else begin : g_low
                assign mask[bi] = low_on;
            end
        end
    endgenerate

endmodule

// File: rtl/io_rd_bitmask.sv
module io_rd_bitmask #(
    parameter int NWIN = 4,
    parameter int DW   = io_rd_bitmask_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              mem_cycle,
    input  logic [NWIN-1:0]   io_win_hit,
    input  logic [2*NWIN-1:0] io_win_mode,
    input  logic [DW-1:0]     card_rdata,
    output logic [DW-1:0]     host_oe,
    output logic [DW-1:0]     host_rdata
);
    import io_rd_bitmask_pkg::*;

    localparam logic [DW-1:0] ALL_ON = {DW{1'b1}};

    logic            any_hit;
    logic [1:0]      sel_mode;
    logic [DW-1:0]   io_mask;
    drive_t          drv_d, drv_q;

    io_rd_win_pick #(.NWIN(NWIN)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (io_win_hit),
        .modes    (io_win_mode),
        .any_hit  (any_hit),
        .sel_mode (sel_mode)
    );

    io_rd_mode_dec #(.DW(DW)) u_dec (
        .mode (sel_mode),
        .mask (io_mask)
    );

    always_comb begin
        drv_d = '0;
        if (rd_strobe) begin
            if (mem_cycle) begin
                drv_d.oe = ALL_ON;
            end else if (any_hit) begin
                drv_d.oe = io_mask;
            end
        end
        drv_d.data = card_rdata & drv_d.oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign host_oe    = drv_q.oe;
    assign host_rdata = drv_q.data;

    // R2: no strobe, nothing driven next cycle
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> host_oe == '0);

    // R8: memory reads are never masked
    p_mem_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && mem_cycle) |=> host_oe == ALL_ON);

    // R9: I/O read without a hit drives nothing
    p_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !mem_cycle && io_win_hit == '0) |=> host_oe == '0);

    // R3: driven bits carry the card data of the previous cycle
    p_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (host_rdata == ($past(card_rdata) & host_oe)));

    // R11: undriven bits read zero
    p_undriven_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata & ~host_oe) == '0);

endmodule

// File: tb/io_rd_bitmask_tb.sv
module io_rd_bitmask_tb;
    localparam int NWIN = 4;
    localparam int DW   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_strobe = 1'b0;
    logic              mem_cycle = 1'b0;
    logic [NWIN-1:0]   io_win_hit = '0;
    logic [2*NWIN-1:0] io_win_mode = '0;
    logic [DW-1:0]     card_rdata = '0;
    logic [DW-1:0]     host_oe;
    logic [DW-1:0]     host_rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    io_rd_bitmask #(.NWIN(NWIN), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .mem_cycle(mem_cycle),
        .io_win_hit(io_win_hit), .io_win_mode(io_win_mode), .card_rdata(card_rdata),
        .host_oe(host_oe), .host_rdata(host_rdata)
    );

    function automatic logic [DW-1:0] exp_oe(logic rd, logic mem, logic [NWIN-1:0] hit,
                                             logic [2*NWIN-1:0] modes);
        logic [1:0] m;
        if (!rd) return '0;
        if (mem) return 8'hFF;
        for (int i = 0; i < NWIN; i++) begin
            if (hit[i]) begin
                m = modes[2*i +: 2];
                case (m)
                    2'b01:   return 8'h7F;
                    2'b10:   return 8'h80;
                    default: return 8'hFF;
                endcase
            end
        end
        return '0;
    endfunction

    task automatic check(string req, logic [DW-1:0] exp_en, logic [DW-1:0] exp_dat);
        n_checks++;
        if (host_oe !== exp_en || host_rdata !== exp_dat) begin
            n_errors++;
            $display("FAIL %s: oe=%h data=%h expected oe=%h data=%h",
                     req, host_oe, host_rdata, exp_en, exp_dat);
        end
    endtask

    // apply at negedge, check at the next negedge (one registered stage, R10)
    task automatic step(string req, logic rd, logic mem, logic [NWIN-1:0] hit,
                        logic [2*NWIN-1:0] modes, logic [DW-1:0] dat);
        logic [DW-1:0] e;
        rd_strobe = rd; mem_cycle = mem; io_win_hit = hit;
        io_win_mode = modes; card_rdata = dat;
        e = exp_oe(rd, mem, hit, modes);
        @(negedge clk);
        check(req, e, dat & e);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: timeout actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1", '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0, '0);

        step("R3", 1, 0, 4'b0001, 8'b00_00_00_00, 8'hA5);
        step("R4", 1, 0, 4'b0001, 8'b00_00_00_01, 8'hFF);
        step("R5", 1, 0, 4'b0001, 8'b00_00_00_10, 8'hFF);
        step("R6", 1, 0, 4'b0001, 8'b00_00_00_11, 8'h3C);
        step("R7", 1, 0, 4'b1010, 8'b01_00_10_00, 8'hFF);
        step("R7", 1, 0, 4'b1100, 8'b10_01_00_00, 8'hC3);
        step("R7", 1, 0, 4'b1111, 8'b00_00_00_10, 8'hFF);
        step("R8", 1, 1, 4'b0001, 8'b01_01_01_01, 8'h96);
        step("R8", 1, 1, 4'b0000, 8'b10_10_10_10, 8'h5A);
        step("R9", 1, 0, 4'b0000, 8'b01_01_01_01, 8'hFF);
        step("R2", 0, 0, 4'b1111, 8'b00_00_00_00, 8'hFF);
        step("R2", 0, 1, 4'b0001, 8'b00_00_00_00, 8'hFF);
        step("R11", 1, 0, 4'b0100, 8'b00_10_00_00, 8'h7F);
        step("R10", 1, 0, 4'b0010, 8'b00_00_01_00, 8'h81);

        for (int k = 0; k < 400; k++) begin
            step("R10", ($urandom % 4) != 0, ($urandom % 5) == 0,
                 NWIN'($urandom), (2*NWIN)'($urandom), DW'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule